// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register file of a general-purpose I/O controller with four banks of 32 pins each. A simple synchronous request bus reads and writes it: one request per cycle, with a registered response one cycle later. For each bank it stores the following:

- the pin directions
- the driven output levels
- the value last written through the set port
- the enables for rising and falling edge detection
- two alternate-function words

It drives the output pins with the output level gated by direction. It flags, for one cycle, exactly the pins whose driven value moved.

Edge detection itself lives in a neighbouring block. This register file hands that block the edge enables and its status vector. On a status write it returns a one-cycle clear mask. A read of a pin-level register also produces a one-cycle notify pulse, which lets a system model react to software polling the pins.

Top module: `gpio_bank_regs`

## Requirements
- R1: Byte offsets, word-aligned, with bank b register at offset shown as (b0, b1, b2, b3): direction (0x00C, 0x010, 0x014, 0x10C); pin level (0x000, 0x004, 0x008, 0x100); set (0x018, 0x01C, 0x020, 0x118); clear (0x024, 0x028, 0x02C, 0x124); rise enable (0x030, 0x034, 0x038, 0x130); fall enable (0x03C, 0x040, 0x044, 0x13C); edge status (0x048, 0x04C, 0x050, 0x148); alternate low word (0x054, 0x05C, 0x064, 0x06C); alternate high word (0x058, 0x060, 0x068, 0x070). Direction reads back the last value written. Every request gives rsp_valid exactly one cycle later.
- R2: A request at offset 0x200 or above reads as zero, changes no state and does not set rsp_err.
- R3: A request below 0x200 that matches no register in R1, including any offset whose low two bits are nonzero, sets rsp_err in its response cycle, reads as zero and changes no state.
- R4: A pin-level read returns, per bit, the output level where the direction bit is 1 (output) and pin_in where it is 0. Writes to a pin-level offset have no effect.
- R5: Each pin-level read raises lvl_rd_pulse for exactly the one cycle in which its response appears; no other request raises it.
- R6: A set write ORs the write data into the bank's output level. A set read returns the data of the last set write to that bank, or 0 after reset.
- R7: A clear write clears the output-level bits where the write data is 1. A clear read returns the constant 0xC1EA5A5A.
- R8: pin_out bit 32*b+i equals bank b's output level AND direction bit i, updated in the cycle after the write. pin_chg is high, for that one cycle only, on exactly the bits of pin_out that changed.
- R9: An edge-status read returns bank b's slice of edge_sts as sampled in the request cycle. An edge-status write with data d puts d on slice b of edge_sts_clr for one cycle (the response cycle), with zeros on the other slices and in all other cycles.
- R10: The rise and fall enables read back their last written value and appear on rise_en and fall_en at bits 32*b+i. The alternate low and high words of bank b read back and appear on af_words at word 2b (low) and 2b+1 (high).
- R11: Synchronous reset clears every register, the response outputs, the notify pulse and the clear mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | BANK_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | BANK_W | Read data (zero for writes) |
| rsp_err | output | 1 | Unmapped offset below 0x200 |
| lvl_rd_pulse | output | 1 | Pin-level read notify |
| pin_in | input | 4*BANK_W | Sampled input levels |
| pin_out | output | 4*BANK_W | Driven output values |
| pin_chg | output | 4*BANK_W | Driven value changed this cycle |
| rise_en | output | 4*BANK_W | Rising-edge enables |
| fall_en | output | 4*BANK_W | Falling-edge enables |
| edge_sts | input | 4*BANK_W | Status from the edge detector |
| edge_sts_clr | output | 4*BANK_W | One-cycle status clear mask |
| af_words | output | 8*BANK_W | Alternate-function words |

## Verification
The bench builds the block with its defaults: 32-bit banks and a 12-bit offset. The offset width puts the whole range from 0x200 up to 0xFFC within reach of the ignored-access checks. It also covers the holes and misaligned offsets below 0x200 and the displaced fourth bank at 0x100. A behavioural model is compared against the design on every cycle. That comparison covers merged pin levels under direction patterns that vary bank by bank, the change flags from set, clear and direction writes, the exact timing of the notify pulse and of the clear mask, and a reset in mid-run.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int NBANK = 4;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LVL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_STS,
        RK_AFLO,
        RK_AFHI,
        RK_FAR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    // Row order of the interleaved block: each row holds three banks, 12 bytes apart.
    function automatic reg_kind_e kind_of_row(input logic [2:0] row);
        case (row)
            3'd0:    return RK_LVL;
            3'd1:    return RK_DIR;
            3'd2:    return RK_SET;
            3'd3:    return RK_CLR;
            3'd4:    return RK_RISE;
            3'd5:    return RK_FALL;
            3'd6:    return RK_STS;
            default: return RK_NONE;
        endcase
    endfunction

    // Decode a 9-bit byte offset below 0x200.
    function automatic reg_sel_t decode_off(input logic [8:0] off);
        reg_sel_t   s;
        logic [5:0] w;
        s.kind = RK_NONE;
        s.bank = 2'd0;
        w      = off[7:2];
        if (off[1:0] == 2'b00) begin
            if (off[8]) begin
                // fourth bank mirrors the first column of the low block
                if ((w % 6'd3) == 6'd0 && w <= 6'd18) begin
                    s.kind = kind_of_row(3'(w / 6'd3));
                    s.bank = 2'd3;
                end
            end else if (w <= 6'd20) begin
                s.kind = kind_of_row(3'(w / 6'd3));
                s.bank = 2'(w % 6'd3);
            end else if (w <= 6'd28) begin
                s.kind = ((w - 6'd21) & 6'd1) != 6'd0 ? RK_AFHI : RK_AFLO;
                s.bank = 2'((w - 6'd21) >> 1);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int HI_W = ADDR_W - 9;

    logic [HI_W-1:0] hi_bits;
    assign hi_bits = addr[ADDR_W-1:9];

    always_comb begin
        if (hi_bits != '0) begin
            sel.kind = RK_FAR;
            sel.bank = 2'd0;
        end else begin
            sel = decode_off(addr[8:0]);
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_regs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] olev,
    output logic [W-1:0] setv,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] af_lo,
    output logic [W-1:0] af_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir   <= '0;
            olev  <= '0;
            setv  <= '0;
            rise  <= '0;
            fall  <= '0;
            af_lo <= '0;
            af_hi <= '0;
        end else if (wr_en) begin
            case (kind)
                RK_DIR:  dir <= wdata;
                RK_SET: begin
                    olev <= olev | wdata;
                    setv <= wdata;
                end
                RK_CLR:  olev  <= olev & ~wdata;
                RK_RISE: rise  <= wdata;
                RK_FALL: fall  <= wdata;
                RK_AFLO: af_lo <= wdata;
                RK_AFHI: af_hi <= wdata;
                default: ;
            endcase
        end
    end

    // R6: every bit named in a set write is high afterwards
    p_set_or_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_SET) |=> ((olev & $past(wdata)) == $past(wdata)));

    // R7: every bit named in a clear write is low afterwards
    p_clr_and_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_CLR) |=> ((olev & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_drive_track.sv
module gpio_drive_track #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] drv,
    output logic [N-1:0] chg
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= drv;
    end

    assign chg = drv ^ prev_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int               BANK_W     = 32,
    parameter int               ADDR_W     = 12,
    parameter logic [BANK_W-1:0] CLR_RD_VAL = 32'hC1EA_5A5A
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BANK_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [BANK_W-1:0]          rsp_rdata,
    output logic                       rsp_err,
    output logic                       lvl_rd_pulse,
    input  logic [NBANK*BANK_W-1:0]    pin_in,
    output logic [NBANK*BANK_W-1:0]    pin_out,
    output logic [NBANK*BANK_W-1:0]    pin_chg,
    output logic [NBANK*BANK_W-1:0]    rise_en,
    output logic [NBANK*BANK_W-1:0]    fall_en,
    input  logic [NBANK*BANK_W-1:0]    edge_sts,
    output logic [NBANK*BANK_W-1:0]    edge_sts_clr,
    output logic [2*NBANK*BANK_W-1:0]  af_words
);

    localparam int NPINS = NBANK * BANK_W;

    reg_sel_t sel;

    logic [BANK_W-1:0] dir_a  [NBANK];
    logic [BANK_W-1:0] olev_a [NBANK];
    logic [BANK_W-1:0] setv_a [NBANK];
    logic [BANK_W-1:0] rise_a [NBANK];
    logic [BANK_W-1:0] fall_a [NBANK];
    logic [BANK_W-1:0] afl_a  [NBANK];
    logic [BANK_W-1:0] afh_a  [NBANK];
    logic [BANK_W-1:0] in_a   [NBANK];
    logic [BANK_W-1:0] sts_a  [NBANK];

    logic              is_rd;
    logic              is_wr;
    logic [BANK_W-1:0] rd_val;
    logic [NPINS-1:0]  drv;

    assign is_rd = req_valid && !req_write;
    assign is_wr = req_valid && req_write;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_bank #(.W(BANK_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (is_wr && sel.bank == 2'(b)),
            .kind  (sel.kind),
            .wdata (req_wdata),
            .dir   (dir_a[b]),
            .olev  (olev_a[b]),
            .setv  (setv_a[b]),
            .rise  (rise_a[b]),
            .fall  (fall_a[b]),
            .af_lo (afl_a[b]),
            .af_hi (afh_a[b])
        );

        assign in_a[b]  = pin_in[b*BANK_W +: BANK_W];
        assign sts_a[b] = edge_sts[b*BANK_W +: BANK_W];
        assign drv[b*BANK_W +: BANK_W]     = olev_a[b] & dir_a[b];
        assign rise_en[b*BANK_W +: BANK_W] = rise_a[b];
        assign fall_en[b*BANK_W +: BANK_W] = fall_a[b];
        assign af_words[(2*b)*BANK_W +: BANK_W]   = afl_a[b];
        assign af_words[(2*b+1)*BANK_W +: BANK_W] = afh_a[b];

        always_ff @(posedge clk) begin
            if (rst)
                edge_sts_clr[b*BANK_W +: BANK_W] <= '0;
            else if (is_wr && sel.kind == RK_STS && sel.bank == 2'(b))
                edge_sts_clr[b*BANK_W +: BANK_W] <= req_wdata;
            else
                edge_sts_clr[b*BANK_W +: BANK_W] <= '0;
        end
    end

    assign pin_out = drv;

    gpio_drive_track #(.N(NPINS)) u_track (
        .clk (clk),
        .rst (rst),
        .drv (drv),
        .chg (pin_chg)
    );

    always_comb begin
        case (sel.kind)
            RK_LVL:  rd_val = (olev_a[sel.bank] & dir_a[sel.bank])
                            | (in_a[sel.bank] & ~dir_a[sel.bank]);
            RK_DIR:  rd_val = dir_a[sel.bank];
            RK_SET:  rd_val = setv_a[sel.bank];
            RK_CLR:  rd_val = CLR_RD_VAL;
            RK_RISE: rd_val = rise_a[sel.bank];
            RK_FALL: rd_val = fall_a[sel.bank];
            RK_STS:  rd_val = sts_a[sel.bank];
            RK_AFLO: rd_val = afl_a[sel.bank];
            RK_AFHI: rd_val = afh_a[sel.bank];
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_err      <= 1'b0;
            lvl_rd_pulse <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_rdata    <= is_rd ? rd_val : '0;
            rsp_err      <= req_valid && sel.kind == RK_NONE;
            lvl_rd_pulse <= is_rd && sel.kind == RK_LVL;
        end
    end

    // R5: a pin-level read is answered with a notify pulse
    p_notify_r5: assert property (@(posedge clk) disable iff (rst)
        (is_rd && sel.kind == RK_LVL) |=> lvl_rd_pulse);

    // R5: the pulse never appears without a read the cycle before
    p_notify_src_r5: assert property (@(posedge clk) disable iff (rst)
        lvl_rd_pulse |-> $past(is_rd));

    // R3: an error response carries no data
    p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    // R2: writes far above the map leave the pins and enables alone
    p_far_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (is_wr && sel.kind == RK_FAR) |=>
            ($stable(pin_out) && $stable(rise_en) && $stable(fall_en) && !rsp_err));

    // R8: a change flag is only raised on a bit whose driven value moved
    p_chg_only_r8: assert property (@(posedge clk) disable iff (rst)
        ((pin_chg & ~(pin_out ^ $past(pin_out))) == '0));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;

    localparam int W  = 32;
    localparam int AW = 12;
    localparam int NP = 4 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0;
    logic          rsp_valid;
    logic [W-1:0]  rsp_rdata;
    logic          rsp_err;
    logic          lvl_rd_pulse;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_chg;
    logic [NP-1:0] rise_en;
    logic [NP-1:0] fall_en;
    logic [NP-1:0] edge_sts = '0;
    logic [NP-1:0] edge_sts_clr;
    logic [2*NP-1:0] af_words;

    always #10 clk = ~clk;

    gpio_bank_regs u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lvl_rd_pulse(lvl_rd_pulse),
        .pin_in(pin_in), .pin_out(pin_out), .pin_chg(pin_chg),
        .rise_en(rise_en), .fall_en(fall_en), .edge_sts(edge_sts),
        .edge_sts_clr(edge_sts_clr), .af_words(af_words)
    );

    // ---------------- reference model ----------------
    logic [W-1:0] m_dir [4], m_olev [4], m_setv [4], m_rise [4], m_fall [4];
    logic [W-1:0] m_af [8];
    logic          e_valid, e_err, e_pulse;
    logic [W-1:0]  e_rdata;
    logic [NP-1:0] e_out, e_chg, e_clr, old_drv;
    string         rd_tag = "R1";
    bit            started = 0;
    int            n_chk = 0, n_fail = 0, cyc = 0;
    int            mk, mb;

    // kinds: 0 none 1 lvl 2 dir 3 set 4 clr 5 rise 6 fall 7 sts 8 af-lo 9 af-hi 10 far
    function automatic int addr_of(int k, int b);
        int base = (b == 3) ? 'h100 : 4 * b;
        if (k == 8) return 'h54 + 8 * b;
        if (k == 9) return 'h58 + 8 * b;
        return base + 12 * (k - 1);
    endfunction

    function automatic void m_find(input int a, output int k, output int b);
        k = 0; b = 0;
        if (a >= 'h200) begin k = 10; return; end
        for (int i = 0; i < 4; i++)
            for (int r = 1; r <= 9; r++)
                if (a == addr_of(r, i)) begin k = r; b = i; end
    endfunction

    function automatic logic [NP-1:0] m_drv();
        logic [NP-1:0] v;
        for (int i = 0; i < 4; i++) v[i*W +: W] = m_olev[i] & m_dir[i];
        return v;
    endfunction

    function automatic logic [2*NP-1:0] m_afv();
        logic [2*NP-1:0] v;
        for (int i = 0; i < 8; i++) v[i*W +: W] = m_af[i];
        return v;
    endfunction

    function automatic logic [NP-1:0] m_en(input bit fall);
        logic [NP-1:0] v;
        for (int i = 0; i < 4; i++) v[i*W +: W] = fall ? m_fall[i] : m_rise[i];
        return v;
    endfunction

    always @(posedge clk) begin
        started = 1;
        e_valid = 0; e_err = 0; e_pulse = 0; e_rdata = '0; e_clr = '0;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_dir[i] = '0; m_olev[i] = '0; m_setv[i] = '0; m_rise[i] = '0; m_fall[i] = '0;
            end
            for (int i = 0; i < 8; i++) m_af[i] = '0;
            e_out = '0; e_chg = '0;
        end else begin
            old_drv = m_drv();
            e_valid = req_valid;
            if (req_valid) begin
                m_find(int'(req_addr), mk, mb);
                e_err = (mk == 0);
                if (!req_write) begin
                    case (mk)
                        1: begin
                            e_rdata = (m_olev[mb] & m_dir[mb]) | (pin_in[mb*W +: W] & ~m_dir[mb]);
                            e_pulse = 1;
                        end
                        2: e_rdata = m_dir[mb];
                        3: e_rdata = m_setv[mb];
                        4: e_rdata = 32'hC1EA_5A5A;
                        5: e_rdata = m_rise[mb];
                        6: e_rdata = m_fall[mb];
                        7: e_rdata = edge_sts[mb*W +: W];
                        8: e_rdata = m_af[2*mb];
                        9: e_rdata = m_af[2*mb+1];
                        default: e_rdata = '0;
                    endcase
                end else begin
                    case (mk)
                        2: m_dir[mb] = req_wdata;
                        3: begin m_olev[mb] = m_olev[mb] | req_wdata; m_setv[mb] = req_wdata; end
                        4: m_olev[mb] = m_olev[mb] & ~req_wdata;
                        5: m_rise[mb] = req_wdata;
                        6: m_fall[mb] = req_wdata;
                        7: e_clr[mb*W +: W] = req_wdata;
                        8: m_af[2*mb] = req_wdata;
                        9: m_af[2*mb+1] = req_wdata;
                        default: ;
                    endcase
                end
            end
            e_out = m_drv();
            e_chg = old_drv ^ e_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [2*NP-1:0] act,
                       input logic [2*NP-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    string cur_tag = "R1";
    always @(negedge clk) begin
        if (started) begin
            chk(rsp_valid === e_valid, "R1 rsp_valid", rsp_valid, e_valid);
            chk(rsp_rdata === e_rdata, cur_tag, rsp_rdata, e_rdata);
            chk(rsp_err === e_err, "R3 rsp_err", rsp_err, e_err);
            chk(lvl_rd_pulse === e_pulse, "R5 notify", lvl_rd_pulse, e_pulse);
            chk(pin_out === e_out, "R8 pin_out", pin_out, e_out);
            chk(pin_chg === e_chg, "R8 pin_chg", pin_chg, e_chg);
            chk(edge_sts_clr === e_clr, "R9 sts_clr", edge_sts_clr, e_clr);
            chk(rise_en === m_en(0), "R10 rise_en", rise_en, m_en(0));
            chk(fall_en === m_en(1), "R10 fall_en", fall_en, m_en(1));
            chk(af_words === m_afv(), "R10 af_words", af_words, m_afv());
        end
        cur_tag = rd_tag;
    end

    // ---------------- stimulus ----------------
    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] nxt(inout logic [31:0] s);
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        return s;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0: return "R3 unmapped";
            1: return "R4 level";
            3: return "R6 set";
            4: return "R7 clear";
            7: return "R9 status";
            10: return "R2 far";
            2: return "R1 dir";
            default: return "R10 enable/af";
        endcase
    endfunction

    task automatic acc(input bit wr, input int a, input logic [31:0] d);
        int k, b;
        @(negedge clk);
        m_find(a, k, b);
        rd_tag    = tag_of(k);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_write = 0; rd_tag = "R1 idle";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: nothing set after reset
        chk(pin_out == '0 && rsp_valid == 0 && af_words == '0 && rise_en == '0 && edge_sts_clr == '0,
            "R11 reset state", {pin_out[7:0], rsp_valid}, '0);
        for (int k = 1; k <= 9; k++) acc(0, addr_of(k, 3), 0);

        for (int b = 0; b < 4; b++) begin
            acc(1, addr_of(2, b), nxt(seed));
            acc(1, addr_of(3, b), nxt(seed));
            acc(1, addr_of(4, b), nxt(seed));
            acc(1, addr_of(3, b), 32'h0000_00F0);
            acc(1, addr_of(5, b), nxt(seed));
            acc(1, addr_of(6, b), nxt(seed));
            acc(1, addr_of(8, b), nxt(seed));
            acc(1, addr_of(9, b), nxt(seed));
            acc(1, addr_of(1, b), 32'hFFFF_FFFF);       // R4 ignored write
            pin_in   = {nxt(seed), nxt(seed), nxt(seed), nxt(seed)};
            edge_sts = {nxt(seed), nxt(seed), nxt(seed), nxt(seed)};
            for (int k = 1; k <= 9; k++) acc(0, addr_of(k, b), 0);
            acc(1, addr_of(7, b), nxt(seed));
            idle();
            acc(1, addr_of(2, b), 32'h0);                // all inputs
            acc(0, addr_of(1, b), 0);
            acc(1, addr_of(2, b), 32'hFFFF_FFFF);        // all outputs
            acc(0, addr_of(1, b), 0);
            acc(1, addr_of(4, b), 32'hFFFF_FFFF);
            acc(1, addr_of(3, b), 32'hA5A5_0001);
            acc(0, addr_of(1, b), 0);
        end
        // R2: far offsets
        acc(1, 'h200, 32'hFFFF_FFFF); acc(1, 'hFFC, 32'hFFFF_FFFF);
        acc(1, 'h30C, 32'h0); acc(0, 'h200, 0); acc(0, 'hFFC, 0);
        for (int b = 0; b < 4; b++) acc(0, addr_of(2, b), 0);
        // R3: holes and misaligned offsets
        acc(0, 'h074, 0); acc(0, 'h0FC, 0); acc(1, 'h104, 32'hFFFF_FFFF);
        acc(1, 'h14C, 32'hFFFF_FFFF); acc(0, 'h1FC, 0); acc(1, 'h00E, 32'hFFFF_FFFF);
        acc(0, 'h002, 0); acc(1, 'h11A, 32'hFFFF_FFFF);
        for (int b = 0; b < 4; b++) acc(0, addr_of(2, b), 0);
        for (int i = 0; i < 40; i++) acc(i[0], addr_of(1 + (i % 9), i % 4), nxt(seed));
        idle();
        // R11: reset in mid-run
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        for (int b = 0; b < 4; b++) begin acc(0, addr_of(2, b), 0); acc(0, addr_of(3, b), 0); end
        idle(); idle();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule